// File: doc/BRIEF.md
# Sequential-Addressing Tree Reduction Unit

This block adds up a tile of integer values. The values sit in a scratchpad that is split into several banks, one bank per datapath lane. Software or an upstream engine fills the tile through a simple write port while the unit is idle, then pulses a start input. The unit then folds the tile onto itself in a logarithmic number of steps. In each step every active lane takes the element at its own index and the element one stride above it, adds them, and writes the result back to its own index. When a step is complete the stride halves. When the stride reaches zero the total is in element 0.

The lane index is used directly as the lower address, so the lanes working on a group always touch consecutive words. Consecutive words fall into distinct banks, so no step ever needs two accesses to the same bank in one cycle. The datapath handles as many lanes per cycle as there are banks. A step with a wide stride is therefore split into several groups, and the step boundary acts as a barrier: the stride only halves after the last group of the step has written back. The result is presented on a sum output together with a done flag. Both stay put until the next start.

Top module: `tree_sum_unit`

## Requirements
- R1: After reset, `done` is 0 and `sumOut` is 0.
- R2: While the unit is idle, a cycle with `wrEn` high stores `wrData` as tile element number `wrAddr`. Element e lives in bank e mod LANES at row e / LANES. Every stored element contributes once to the next sum.
- R3: After a run, `sumOut` equals the sum of all TILE elements that were loaded, taken modulo 2^W.
- R4: Values are W-bit two's-complement. Overflow wraps silently; for example, 512 copies of 0x7FFFFFFF give 0xFFFFFE00.
- R5: The strides visited are TILE/2, TILE/4, ..., 1. The step with stride s takes ceil(s/LANES) cycles. If start is sampled at clock edge 0, `done` is first high after edge N, where N is the sum of all those step lengths; this is 66 for TILE=512 and LANES=8.
- R6: Once high, `done` and `sumOut` hold their values until the next start is sampled, and `done` is low from the edge that samples that start.
- R7: A start pulse that arrives while a run is in progress is ignored: the run neither restarts nor lengthens.
- R8: Writes presented while a run is in progress are ignored and do not change the result.
- R9: During each step only lanes with an index below the current stride are active, and the active lanes of a cycle read their upper operands from pairwise distinct banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reduction of the loaded tile (ignored while running) |
| wrEn | input | 1 | Load strobe for one tile element (ignored while running) |
| wrAddr | input | log2(TILE) | Element index being loaded |
| wrData | input | W | Element value being loaded |
| done | output | 1 | Result valid; held until the next start |
| sumOut | output | W | Wrapped sum of the tile |

## Verification
The sum and the done flag are due exactly N+1 falling edges after the falling edge at which start is raised, where N is the step-length total from R5. The bench computes N itself from TILE and LANES. Each run's expected sum and that latency go into a queue when start is driven. A monitor working on falling edges measures the latency from its own cycle counter when done rises, and compares both values with the queued item. The clearing of done is sampled on the first falling edge after a start. The hold of the result is sampled a number of cycles after done rises, with no start in between.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  // Strobes from control to datapath; at most one of load/accum is high.
  typedef struct packed {
    logic load;     // store one element from the write port
    logic accum;    // active lanes add and write back this cycle
    logic capture;  // final step: latch lane 0 result as the sum
  } tsuStrobe_t;
endpackage

// File: rtl/tsu_ctrl.sv
module tsu_ctrl
  import tsu_pkg::*;
#(
  parameter int TILE  = 512,
  parameter int LANES = 8,
  localparam int IW   = $clog2(TILE)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          wrEn,
  output tsuStrobe_t    strobe,
  output logic [IW-1:0] stride,
  output logic [IW-1:0] base,
  output logic          done
);
  typedef enum logic {S_IDLE, S_RUN} ctrlState_t;

  localparam logic [IW:0]   LANES_W  = (IW+1)'(LANES);
  localparam logic [IW-1:0] HALF     = IW'(TILE / 2);
  localparam logic [IW-1:0] ONE      = IW'(1);

  ctrlState_t state;
  logic       lastGroup;

  // The barrier: the last group of a step is the one whose lanes reach the stride.
  always_comb begin
    lastGroup      = ({1'b0, base} + LANES_W) >= {1'b0, stride};
    strobe.load    = (state == S_IDLE) && wrEn;
    strobe.accum   = (state == S_RUN);
    strobe.capture = (state == S_RUN) && lastGroup && (stride == ONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      stride <= '0;
      base   <= '0;
      done   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state  <= S_RUN;
            stride <= HALF;
            base   <= '0;
            done   <= 1'b0;
          end
        end
        S_RUN: begin
          if (lastGroup) begin
            base <= '0;
            if (stride == ONE) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              stride <= stride >> 1;
            end
          end else begin
            base <= base + IW'(LANES);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsu_datapath.sv
module tsu_datapath
  import tsu_pkg::*;
#(
  parameter int TILE  = 512,
  parameter int LANES = 8,
  parameter int W     = 32,
  localparam int IW   = $clog2(TILE)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tsuStrobe_t       strobe,
  input  logic [IW-1:0]    stride,
  input  logic [IW-1:0]    base,
  input  logic [IW-1:0]    wrAddr,
  input  logic [W-1:0]     wrData,
  output logic [W-1:0]     sumOut,
  output logic [LANES-1:0] activeMask,
  output logic [LANES-1:0] bankHit
);
  localparam int LB   = $clog2(LANES);
  localparam int ROWS = TILE / LANES;
  localparam int RB   = IW - LB;

  // One storage array per bank; element e -> bank e%LANES, row e/LANES.
  logic [W-1:0]    bankMem [LANES][ROWS];

  logic [IW-1:0]   loIdx   [LANES];
  logic [IW-1:0]   hiIdx   [LANES];
  logic [LB-1:0]   hiBank  [LANES];
  logic [RB-1:0]   loRow   [LANES];
  logic [RB-1:0]   hiRow   [LANES];
  logic [W-1:0]    laneSum [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    // Lower operand: the lane's own index, always in bank j.
    assign loIdx[j]      = base + IW'(j);
    assign hiIdx[j]      = loIdx[j] + stride;
    assign activeMask[j] = loIdx[j] < stride;
    assign loRow[j]      = loIdx[j][IW-1:LB];
    assign hiRow[j]      = hiIdx[j][IW-1:LB];
    assign hiBank[j]     = hiIdx[j][LB-1:0];
    assign laneSum[j]    = bankMem[j][loRow[j]] + bankMem[hiBank[j]][hiRow[j]];
  end

  // Which banks the active lanes read their upper operand from.
  always_comb begin
    bankHit = '0;
    for (int j = 0; j < LANES; j++) begin
      if (activeMask[j]) bankHit[hiBank[j]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      bankMem[wrAddr[LB-1:0]][wrAddr[IW-1:LB]] <= wrData;
    end
    if (strobe.accum) begin
      for (int j = 0; j < LANES; j++) begin
        if (activeMask[j]) bankMem[j][loRow[j]] <= laneSum[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumOut <= '0;
    end else if (strobe.capture) begin
      sumOut <= laneSum[0];
    end
  end
endmodule

// File: rtl/tree_sum_unit.sv
module tree_sum_unit
  import tsu_pkg::*;
#(
  parameter int TILE  = 512,
  parameter int LANES = 8,
  parameter int W     = 32,
  localparam int IW   = $clog2(TILE)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          wrEn,
  input  logic [IW-1:0] wrAddr,
  input  logic [W-1:0]  wrData,
  output logic          done,
  output logic [W-1:0]  sumOut
);
  tsuStrobe_t       strobe;
  logic [IW-1:0]    stride;
  logic [IW-1:0]    base;
  logic [LANES-1:0] activeMask;
  logic [LANES-1:0] bankHit;

  tsu_ctrl #(.TILE(TILE), .LANES(LANES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .wrEn   (wrEn),
    .strobe (strobe),
    .stride (stride),
    .base   (base),
    .done   (done)
  );

  tsu_datapath #(.TILE(TILE), .LANES(LANES), .W(W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .stride     (stride),
    .base       (base),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .sumOut     (sumOut),
    .activeMask (activeMask),
    .bankHit    (bankHit)
  );
endmodule

// File: rtl/tsu_chk.sv
module tsu_chk
  import tsu_pkg::*;
#(
  parameter int TILE  = 512,
  parameter int LANES = 8,
  parameter int W     = 32,
  localparam int IW   = $clog2(TILE)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             done,
  input logic [W-1:0]     sumOut,
  input tsuStrobe_t       strobe,
  input logic [IW-1:0]    stride,
  input logic [LANES-1:0] activeMask,
  input logic [LANES-1:0] bankHit
);
  // R9: upper operands of active lanes come from distinct banks
  a_r9_conflict_free: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accum |-> $countones(bankHit) == $countones(activeMask));

  // R9: active lanes form a contiguous run starting at lane 0
  a_r9_lanes_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accum |-> activeMask[0] && ((activeMask & (activeMask + 1'b1)) == '0));

  // R5: between consecutive working cycles the stride only ever halves
  a_r5_stride_halves: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accum && $past(strobe.accum) && (stride != $past(stride))
      |-> stride == ($past(stride) >> 1));

  // R6: result held while no start arrives
  a_r6_done_held: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(sumOut));

  // R6: a sampled start clears done
  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    done && start |=> !done);

  // R5: no work happens once the result is flagged
  a_r5_idle_when_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !strobe.accum && !strobe.capture);
endmodule

bind tree_sum_unit tsu_chk #(.TILE(TILE), .LANES(LANES), .W(W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .done       (done),
  .sumOut     (sumOut),
  .strobe     (strobe),
  .stride     (stride),
  .activeMask (activeMask),
  .bankHit    (bankHit)
);

// File: tb/test_tree_sum_unit.sv
`timescale 1ns/1ps
module test_tree_sum_unit;
  localparam int TILE  = 512;
  localparam int LANES = 8;
  localparam int W     = 32;
  localparam int IW    = $clog2(TILE);

  typedef struct {
    logic [W-1:0] sum;
    string        tag;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          wrEn = 1'b0;
  logic [IW-1:0] wrAddr = '0;
  logic [W-1:0]  wrData = '0;
  logic          done;
  logic [W-1:0]  sumOut;

  int total = 0;
  int bad = 0;
  int cycle = 0;
  int startMark = 0;
  int resultsSeen = 0;
  int expLat;
  logic [W-1:0] lastSum;
  expItem_t expQ[$];

  tree_sum_unit #(.TILE(TILE), .LANES(LANES), .W(W)) i_tree_sum_unit (
    .clk(clk), .rstN(rstN), .start(start), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .done(done), .sumOut(sumOut)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  function automatic int stepTotal();
    int n = 0;
    for (int s = TILE / 2; s > 0; s = s / 2) n += (s + LANES - 1) / LANES;
    return n;
  endfunction

  function automatic logic [W-1:0] patVal(int pid, int e);
    case (pid)
      0: return 32'd1;
      1: return W'(e);
      2: return (e % 2 == 1) ? -W'(e) : W'(3 * e);
      3: return 32'h7FFF_FFFF;
      4: return (W'(e) * 32'h9E37_79B1) ^ (W'(e) << 7);
      5: return (e == TILE - 1) ? 32'hABCD_1234 : '0;
      6: return (e == 0) ? 32'h8000_0001 : '0;
      default: return (e == 129) ? 32'h0000_5A5A : '0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadTile(int pid);
    for (int e = 0; e < TILE; e++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = IW'(e); wrData = patVal(pid, e);
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // mode: 0 plain, 1 extra start mid-run (R7), 2 write mid-run (R8)
  task automatic runTile(int pid, string tag, int mode);
    expItem_t it;
    logic [W-1:0] acc = '0;
    int target = resultsSeen + 1;
    for (int e = 0; e < TILE; e++) acc += patVal(pid, e);
    loadTile(pid);
    it.sum = acc; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    start = 1'b1; startMark = cycle;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b0, "R6 done cleared by start", W'(done), '0);
    repeat (10) @(negedge clk);
    if (mode == 1) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end else if (mode == 2) begin
      wrEn = 1'b1; wrAddr = '0; wrData = 32'hDEAD_BEEF;
      @(negedge clk);
      wrAddr = IW'(TILE - 1);
      @(negedge clk);
      wrEn = 1'b0;
    end
    while (resultsSeen < target) @(negedge clk);
    lastSum = acc;
  endtask

  // Monitor: compare each completed run against the queue
  initial begin
    logic prevDone = 1'b0;
    expItem_t it;
    forever begin
      @(negedge clk);
      if (rstN && done && !prevDone) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected done", sumOut, '0);
        end else begin
          it = expQ.pop_front();
          check(sumOut === it.sum, it.tag, sumOut, it.sum);
          check((cycle - startMark) == expLat, "R5 latency",
                W'(cycle - startMark), W'(expLat));
        end
        resultsSeen++;
      end
      prevDone = done;
    end
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    expLat = stepTotal() + 1;
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R1 done after reset", W'(done), '0);
    check(sumOut === '0, "R1 sum after reset", sumOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(done === 1'b0, "R1 done idle", W'(done), '0);

    runTile(0, "R3 all ones", 0);
    runTile(1, "R3 ascending", 0);
    repeat (15) @(negedge clk);
    check(done === 1'b1, "R6 done held", W'(done), 1);
    check(sumOut === lastSum, "R6 sum held", sumOut, lastSum);
    runTile(2, "R3 mixed signs + R7 start ignored", 1);
    runTile(3, "R4 wrap on overflow", 0);
    check(sumOut === 32'hFFFF_FE00, "R4 wrap constant", sumOut, 32'hFFFF_FE00);
    runTile(4, "R3 scrambled + R8 write ignored", 2);
    runTile(5, "R2 last element", 0);
    runTile(6, "R2 element zero", 0);
    runTile(7, "R2 element 129", 0);
    runTile(1, "R9 ascending repeat", 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule